// File: doc/BRIEF.md
# Lockable GPIO Configuration Register Bank

This block holds the configuration state of a small I/O controller behind a plain host register interface (address, write data, write strobe, combinational read data). One global register carries the pin-function select field together with a global freeze bit. A row of per-pin registers, one byte each at consecutive addresses, carries the output enable, the output type, the pull-up enable and the driven data value of each GPIO pin, plus a per-pin freeze bit. The stored values drive the per-pin control outputs directly.

Both freeze bits can only be set by software. A hardware reset is the only thing that clears them. Once the global freeze bit is set, the function-select field ignores writes. Once a pin's freeze bit is set, every attribute of that pin, and the freeze bit itself, ignores writes. A write to a frozen field completes normally on the bus and leaves the stored value alone. A write that sets a freeze bit still applies the other fields it carries in the same cycle. With both mechanisms unused, every field can be written freely.

Top module: `gpio_lock_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every stored bit is 0. This means the function select is 0, both kinds of freeze bit are clear, outputs are disabled, the output type is push-pull, the pull-up is off and the driven data is 0.
- R2: With the global freeze bit clear, a write to address 0 stores `wdata[6:0]` as the function select. The new value appears on `func_sel` after that clock edge, and reading address 0 returns {freeze, select}.
- R3: Once bit 7 of address 0 reads 1, later writes to address 0 leave `func_sel` unchanged.
- R4: Software cannot clear the global freeze bit. Writing 0 to bit 7 of address 0 leaves it at 1. Only `rst_n` low clears it.
- R5: Pin i's register sits at address PIN_BASE+i (default 8). Its fields are bit 0 output enable, bit 1 open-drain select, bit 2 pull-up enable, bit 3 driven data and bit 7 pin freeze. Bits 6:4 read as 0. The fields drive `pin_oe`, `pin_od`, `pin_pu`, `pin_dout` and `pin_locked` from the clock edge that writes them.
- R6: Once a pin's freeze bit is set, writes to that pin's register change none of its five stored bits, and the freeze bit cannot be cleared by software.
- R7: A pin's freeze bit affects only that pin. The other pins' registers stay writable.
- R8: A write that sets a freeze bit (global or per-pin) also stores the other fields of the same write.
- R9: The global freeze bit has no effect on pin registers, and pin freeze bits have no effect on the function select.
- R10: Addresses that are neither 0 nor a pin register read as 0, and writes to them change no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (5) | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| func_sel | output | FSEL_W (7) | Pin-function select field |
| cfg_locked | output | 1 | Global freeze bit |
| pin_oe | output | NUM_PINS (8) | Per-pin output enable |
| pin_od | output | NUM_PINS (8) | Per-pin output type, 1 means open-drain |
| pin_pu | output | NUM_PINS (8) | Per-pin static pull-up enable |
| pin_dout | output | NUM_PINS (8) | Per-pin driven data value |
| pin_locked | output | NUM_PINS (8) | Per-pin freeze bit |

## Verification
The bench goes after these cases:
- A write that sets a freeze bit while changing other fields. A design that evaluated the freeze too early would drop those fields.
- A write of 0 to a set freeze bit. A design that treated the bit as ordinary storage would unfreeze.
- Freezing one pin, then writing its neighbours and the global register. A decoder that shared the freeze would stall unrelated fields.
- Writes to unmapped addresses, and a hardware reset in the middle of the run. An aliasing decoder would corrupt real registers, and a freeze that survived reset would show up as frozen fields.

Random traffic with occasional freezes is compared against a reference model held in the bench.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
   localparam int CFG_BYTE_W = 8;
   localparam int OE_POS     = 0;
   localparam int OD_POS     = 1;
   localparam int PU_POS     = 2;
   localparam int DOUT_POS   = 3;
   localparam int FRZ_POS    = 7;

   typedef struct packed {
      logic frz;
      logic dout;
      logic pull_up;
      logic open_drain;
      logic out_en;
   } pin_cfg_t;

   function automatic logic [CFG_BYTE_W-1:0] pin_to_byte(pin_cfg_t c);
      logic [CFG_BYTE_W-1:0] b;
      b = '0;
      b[OE_POS]   = c.out_en;
      b[OD_POS]   = c.open_drain;
      b[PU_POS]   = c.pull_up;
      b[DOUT_POS] = c.dout;
      b[FRZ_POS]  = c.frz;
      return b;
   endfunction

   function automatic pin_cfg_t byte_to_pin(logic [CFG_BYTE_W-1:0] b);
      pin_cfg_t c;
      c.out_en     = b[OE_POS];
      c.open_drain = b[OD_POS];
      c.pull_up    = b[PU_POS];
      c.dout       = b[DOUT_POS];
      c.frz        = b[FRZ_POS];
      return c;
   endfunction
endpackage

// File: rtl/gpio_glob_cfg.sv
module gpio_glob_cfg
   import gpio_lock_pkg::*;
#(
   parameter int FSEL_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_hit,
   input  logic [CFG_BYTE_W-1:0] wdata,
   output logic [FSEL_W-1:0]     fsel,
   output logic                  frozen,
   output logic [CFG_BYTE_W-1:0] rd_byte
);
   if (FSEL_W < 1 || FSEL_W > FRZ_POS) begin : g_bad_fsel
      $error("FSEL_W must fit below the freeze bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel   <= '0;
         frozen <= 1'b0;
      end else if (wr_hit && !frozen) begin
         fsel   <= wdata[FSEL_W-1:0];
         frozen <= wdata[FRZ_POS];
      end
   end

   always_comb begin
      rd_byte          = CFG_BYTE_W'(fsel);
      rd_byte[FRZ_POS] = frozen;
   end

   assert_glob_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> frozen);
   assert_fsel_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(fsel));
   assert_fsel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !frozen) |=> (fsel == $past(wdata[FSEL_W-1:0])));
   assert_fsel_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(fsel) && $stable(frozen));
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
   import gpio_lock_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_hit,
   input  logic [CFG_BYTE_W-1:0] wdata,
   output pin_cfg_t              cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_hit && !cfg.frz) begin
         cfg <= byte_to_pin(wdata);
      end
   end

   assert_pin_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.frz |=> $stable(cfg));
   assert_pin_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !cfg.frz) |=> (cfg.out_en == $past(wdata[OE_POS]))
                               && (cfg.frz == $past(wdata[FRZ_POS])));
   assert_pin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(cfg));
endmodule

// File: rtl/gpio_cfg_rdmux.sv
module gpio_cfg_rdmux
   import gpio_lock_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 5,
   parameter int PIN_BASE = 8
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [CFG_BYTE_W-1:0]          glob_byte,
   input  logic [NUM_PINS*CFG_BYTE_W-1:0] pin_bytes,
   output logic [CFG_BYTE_W-1:0]          rdata
);
   always_comb begin
      rdata = '0;
      if (addr == '0) rdata = glob_byte;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (addr == ADDR_W'(PIN_BASE + i))
            rdata = pin_bytes[i*CFG_BYTE_W +: CFG_BYTE_W];
      end
   end
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
   import gpio_lock_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 5,
   parameter int PIN_BASE = 8,
   parameter int FSEL_W   = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [CFG_BYTE_W-1:0] wdata,
   output logic [CFG_BYTE_W-1:0] rdata,
   output logic [FSEL_W-1:0]     func_sel,
   output logic                  cfg_locked,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   pin_od,
   output logic [NUM_PINS-1:0]   pin_pu,
   output logic [NUM_PINS-1:0]   pin_dout,
   output logic [NUM_PINS-1:0]   pin_locked
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (PIN_BASE < 1 || PIN_BASE + NUM_PINS > ADDR_SPAN) begin : g_bad_map
      $error("pin registers must fit in the address space above address 0");
   end

   logic                           glob_hit;
   logic [CFG_BYTE_W-1:0]          glob_byte;
   logic [NUM_PINS*CFG_BYTE_W-1:0] pin_bytes;

   assign glob_hit = wr_en && (addr == '0);

   gpio_glob_cfg #(.FSEL_W(FSEL_W)) i_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (glob_hit),
      .wdata   (wdata),
      .fsel    (func_sel),
      .frozen  (cfg_locked),
      .rd_byte (glob_byte)
   );

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PIN_BASE + g);
      logic     hit;
      pin_cfg_t cfg;

      assign hit = wr_en && (addr == MY_ADDR);

      gpio_pin_cfg i_pin (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (hit),
         .wdata  (wdata),
         .cfg    (cfg)
      );

      assign pin_oe[g]     = cfg.out_en;
      assign pin_od[g]     = cfg.open_drain;
      assign pin_pu[g]     = cfg.pull_up;
      assign pin_dout[g]   = cfg.dout;
      assign pin_locked[g] = cfg.frz;
      assign pin_bytes[g*CFG_BYTE_W +: CFG_BYTE_W] = pin_to_byte(cfg);
   end

   gpio_cfg_rdmux #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .PIN_BASE (PIN_BASE)
   ) i_rdmux (
      .addr      (addr),
      .glob_byte (glob_byte),
      .pin_bytes (pin_bytes),
      .rdata     (rdata)
   );

   assert_rst_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (pin_locked == '0) && !cfg_locked && (func_sel == '0));
   assert_pinfrz_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_locked & ~$past(pin_locked)) == (pin_locked ^ $past(pin_locked)));
   assert_glob_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=> $stable(pin_oe) && $stable(pin_locked));
endmodule

// File: tb/test_gpio_lock_bank.sv
`timescale 1ns/1ps
module test_gpio_lock_bank;
   localparam int NP = 8;
   localparam int AW = 5;
   localparam int PB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [6:0]    func_sel;
   logic          cfg_locked;
   logic [NP-1:0] pin_oe, pin_od, pin_pu, pin_dout, pin_locked;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] m_glob;
   logic [7:0] m_pin [NP];

   always #2 clk = ~clk;

   gpio_lock_bank #(.NUM_PINS(NP), .ADDR_W(AW), .PIN_BASE(PB), .FSEL_W(7)) i_gpio_lock_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .func_sel(func_sel), .cfg_locked(cfg_locked),
      .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu),
      .pin_dout(pin_dout), .pin_locked(pin_locked)
   );

   function automatic logic [7:0] nxt_glob(logic [7:0] old, logic [7:0] d);
      return old[7] ? old : d;
   endfunction

   function automatic logic [7:0] nxt_pin(logic [7:0] old, logic [7:0] d);
      return old[7] ? old : (d & 8'h8F);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_glob = '0;
      for (int i = 0; i < NP; i++) m_pin[i] = '0;
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 0) m_glob = nxt_glob(m_glob, d);
      else if (a >= PB && a < PB + NP) m_pin[a-PB] = nxt_pin(m_pin[a-PB], d);
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a);
      logic [7:0] e;
      addr = a;
      #1;
      if (a == 0) e = m_glob;
      else if (a >= PB && a < PB + NP) e = m_pin[a-PB];
      else e = 8'h00;
      chk(tag, rdata, e);
   endtask

   task automatic outs_chk(string tag);
      logic [NP-1:0] eo, ed, ep, eq, el;
      for (int i = 0; i < NP; i++) begin
         eo[i] = m_pin[i][0]; ed[i] = m_pin[i][1]; ep[i] = m_pin[i][2];
         eq[i] = m_pin[i][3]; el[i] = m_pin[i][7];
      end
      chk({tag, " func_sel"}, func_sel, m_glob[6:0]);
      chk({tag, " cfg_locked"}, cfg_locked, m_glob[7]);
      chk({tag, " pin_oe"}, pin_oe, eo);
      chk({tag, " pin_od"}, pin_od, ed);
      chk({tag, " pin_pu"}, pin_pu, ep);
      chk({tag, " pin_dout"}, pin_dout, eq);
      chk({tag, " pin_locked"}, pin_locked, el);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      logic [AW-1:0] a;
      logic [7:0] d;
      void'($urandom(32'h5eed_1234));
      model_reset();
      // R1: state during reset
      @(negedge clk);
      outs_chk("R1 in reset");
      rd_chk("R1 in reset rd glob", 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      outs_chk("R1 after reset");
      rd_chk("R1 after reset rd pin0", PB);

      // R2: unlocked global writes
      wr(0, 8'h5A); outs_chk("R2 glob write"); rd_chk("R2 glob read", 0);
      wr(0, 8'h25); outs_chk("R2 glob rewrite");

      // R5: pin field layout, reserved bits read 0
      wr(PB + 2, 8'h7F); rd_chk("R5 reserved bits zero", PB + 2);
      outs_chk("R5 pin2 outputs");
      wr(PB + 5, 8'h0A); outs_chk("R5 pin5 outputs");

      // R10: unmapped addresses
      wr(3, 8'hFF); outs_chk("R10 write unmapped 3"); rd_chk("R10 read unmapped 3", 3);
      wr(PB + NP, 8'hFF); outs_chk("R10 write unmapped top");
      rd_chk("R10 read unmapped top", PB + NP);

      // R8 + R6: freezing pin 5 while changing its fields
      wr(PB + 5, 8'h85); outs_chk("R8 pin freeze applies fields");
      wr(PB + 5, 8'h0F); outs_chk("R6 pin frozen write ignored");
      rd_chk("R6 pin frozen read", PB + 5);
      wr(PB + 5, 8'h00); chk("R6 pin freeze not clearable", pin_locked[5], 1'b1);

      // R7: neighbours stay writable
      wr(PB + 4, 8'h03); wr(PB + 6, 8'h0C); outs_chk("R7 neighbours writable");

      // R9: pin freeze does not touch global
      wr(0, 8'h11); outs_chk("R9 glob writable with pin frozen");

      // R8 + R3: global freeze with new select
      wr(0, 8'hB3); outs_chk("R8 glob freeze applies select");
      wr(0, 8'h4C); outs_chk("R3 glob frozen write ignored");
      chk("R3 func_sel held", func_sel, 7'h33);
      // R4: cannot clear by writing 0
      wr(0, 8'h00); chk("R4 glob freeze sticky", cfg_locked, 1'b1);
      // R9: global freeze leaves pins writable
      wr(PB + 1, 8'h0E); outs_chk("R9 pins writable with glob frozen");

      // R4/R1: reset clears freezes
      hw_reset();
      @(negedge clk);
      outs_chk("R4 reset clears freezes");
      wr(0, 8'h22); outs_chk("R4 glob writable after reset");

      // random traffic with occasional freezes and resets
      for (int k = 0; k < 2000; k++) begin
         a = AW'($urandom_range(0, 20));
         d = 8'($urandom);
         if ($urandom_range(0, 15) != 0) d[7] = 1'b0;
         if ($urandom_range(0, 399) == 0) hw_reset();
         wr(a, d);
         rd_chk("R2 R5 R6 R10 random read", a);
         outs_chk("R3 R6 R7 random outputs");
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule